// File: doc/BRIEF.md
# Audio Function Configuration Header

This block holds the type-0 configuration header of a multimedia audio function, plus a small group of vendor-specific words. These words hold legacy control, subsystem ID shadows and a power-management mode bit. A bus front end that has already decoded a configuration cycle drives it through a simple port. The port carries a dword index (byte offset divided by four), a read strobe, a write strobe, four active-low byte enables and 32-bit write data. The front end gets 32-bit read data back one cycle after the read strobe.

The header drives the function's controls: memory decode enable, bus mastering enable, parity response and system-error enable. It also drives the memory base address, both legacy control words and a capability-enable flag. An external ID ROM reader reports whether a ROM is fitted and the two subsystem IDs it loaded. When a ROM is fitted, those IDs replace the software-written shadow values in the read-only subsystem dword. Error event pulses from the bus logic set sticky status flags, and software clears each flag by writing a one to it.

Top module: `cfg_space`

## Requirements
- R1: Dword indices outside the implemented set (00h, 01h, 02h, 03h, 04h, 0Bh, 0Dh, 0Fh, 10h, 11h, 14h, 16h) read 00000000h, and writes to them change nothing.
- R2: A write updates only the byte lanes whose enable (`cfg_be_n[k]` low, lane k = bits 8k+7..8k) is asserted. Read-only bytes in an enabled lane stay unchanged, and the enabled writable bytes of the same dword still update.
- R3: In the command word (low half of index 01h), only bit 1 (memory enable), bit 2 (bus master), bit 6 (parity response) and bit 8 (system-error enable) are writable. All four reset to 0 and drive `mem_en`, `bm_en`, `perr_resp` and `serr_en`. Every other command bit reads 0.
- R4: The status word (high half of index 01h) resets to 0210h, and bits 10:9 read 01. `evt_set[0..5]` sets status bits 8, 11, 12, 13, 14 and 15 respectively. Writing 1 to a flag clears it, and writing 0 leaves it. A set and a clear in the same cycle leave the flag set.
- R5: Bit 0 of index 16h is a writable power-mode bit that resets to 0. While it is 0, status bit 4 reads 1, index 0Dh reads 00000050h, index 14h reads 00000001h and `cap_en` is 1. While it is 1, status bit 4, index 0Dh and index 14h read 0 and `cap_en` is 0.
- R6: Index 00h reads 000D1073h. Index 02h reads 04010003h (base class 04h, subclass 01h, interface 00h, revision 03h). The top byte of index 0Fh reads 19h, byte 2 reads 05h and byte 1 reads 01h. Index 03h bytes 3, 2 and 0 read 00h. Writes to any of these hardwired bytes have no effect.
- R7: Index 04h is a 32 KB, 32-bit, non-prefetchable memory base. Bits 31:15 are writable, bits 14:0 read 0, and after an all-ones write it reads FFFF8000h. Bits 31:15 drive `mem_base`.
- R8: Index 0Bh reads {subsystem ID, subsystem vendor ID}. With `eeprom_present` low, it shows the writable shadow at index 11h (reset 000D1073h). With `eeprom_present` high, it shows {`ee_sub_id`, `ee_sub_vid`}, and writes to index 11h do not reach it.
- R9: Index 10h resets to 0000907Fh and is fully writable. The low half drives `legacy_ctl` and the high half drives `legacy_ext`.
- R10: With `rst` high at a clock edge, all writable state and all status flags return to their reset values.
- R11: Read data is registered. `cfg_rdata` shows the addressed dword on the cycle after `cfg_rd`, and it holds that value until the next read.
- R12: Byte 1 of index 03h (latency timer) and byte 0 of index 0Fh (interrupt line) are writable and reset to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 6 | Dword index of the access |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_be_n | input | 4 | Active-low byte lane enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| evt_set | input | 6 | Status event pulses (bits 8, 11..15) |
| eeprom_present | input | 1 | External ID ROM fitted |
| ee_sub_vid | input | 16 | Subsystem vendor ID from ROM |
| ee_sub_id | input | 16 | Subsystem ID from ROM |
| mem_en | output | 1 | Memory decode enable |
| bm_en | output | 1 | Bus master enable |
| perr_resp | output | 1 | Parity error response enable |
| serr_en | output | 1 | System error drive enable |
| mem_base | output | 17 | Memory base address bits 31:15 |
| legacy_ctl | output | 16 | Legacy control word |
| legacy_ext | output | 16 | Extended legacy control word |
| cap_en | output | 1 | Capability list advertised |

## Verification
The hardest case to reach from the ports is a status flag being set and cleared in the same cycle. It needs an event pulse that lines up exactly with a one-written to the top byte lane of the command/status dword. The bench drives `evt_set` and the write strobe on the same falling edge to get there. It then reads back the flags to confirm that set wins. The same test also covers partial clears, where only some flags are written with ones and the command lanes are left disabled. This shows that the clear-on-one path and the command byte lanes do not disturb each other.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    localparam int IDX_W  = 6;
    localparam int N_EVT  = 6;

    // dword indices of implemented words
    localparam logic [IDX_W-1:0] IDX_ID     = 6'h00;
    localparam logic [IDX_W-1:0] IDX_CMDSTS = 6'h01;
    localparam logic [IDX_W-1:0] IDX_CLASS  = 6'h02;
    localparam logic [IDX_W-1:0] IDX_HDR    = 6'h03;
    localparam logic [IDX_W-1:0] IDX_BAR    = 6'h04;
    localparam logic [IDX_W-1:0] IDX_SUBSYS = 6'h0B;
    localparam logic [IDX_W-1:0] IDX_CAPPTR = 6'h0D;
    localparam logic [IDX_W-1:0] IDX_INTR   = 6'h0F;
    localparam logic [IDX_W-1:0] IDX_LEGACY = 6'h10;
    localparam logic [IDX_W-1:0] IDX_SUBWR  = 6'h11;
    localparam logic [IDX_W-1:0] IDX_PMCAP  = 6'h14;
    localparam logic [IDX_W-1:0] IDX_PMODE  = 6'h16;

    // slots of the writable-word array
    localparam int S_CMD    = 0;
    localparam int S_HDR    = 1;
    localparam int S_BAR    = 2;
    localparam int S_INTR   = 3;
    localparam int S_LEGACY = 4;
    localparam int S_SUBWR  = 5;
    localparam int S_PMODE  = 6;
    localparam int N_RW     = 7;

    localparam logic [7:0] CAP_OFFSET = 8'h50;
    localparam logic [7:0] PM_CAP_ID  = 8'h01;

    typedef struct packed {
        logic serr_en;
        logic perr_resp;
        logic bm_en;
        logic mem_en;
    } cmd_ctl_t;

    function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{~be_n[b]}};
        return m;
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be_n,
                                               input logic [31:0] wmask);
        logic [31:0] m;
        m = lane_mask(be_n) & wmask;
        return (old_v & ~m) | (new_v & m);
    endfunction

    function automatic cmd_ctl_t decode_cmd(input logic [15:0] w);
        cmd_ctl_t c;
        c.mem_en    = w[1];
        c.bm_en     = w[2];
        c.perr_resp = w[6];
        c.serr_en   = w[8];
        return c;
    endfunction

    function automatic logic is_implemented(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_ID, IDX_CMDSTS, IDX_CLASS, IDX_HDR, IDX_BAR, IDX_SUBSYS,
            IDX_CAPPTR, IDX_INTR, IDX_LEGACY, IDX_SUBWR, IDX_PMCAP,
            IDX_PMODE: return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_rw_dword.sv
module cfg_rw_dword
    import cfg_space_pkg::*;
#(
    parameter logic [31:0] RST_VAL = 32'h0,
    parameter logic [31:0] WMASK   = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_sel,
    input  logic [3:0]  be_n,
    input  logic [31:0] wdata,
    output logic [31:0] q
);

    always_ff @(posedge clk) begin
        if (rst)         q <= RST_VAL;
        else if (wr_sel) q <= lane_merge(q, wdata, be_n, WMASK);
    end

endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
    import cfg_space_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [3:0]       be_n,
    input  logic [31:0]      wdata,
    input  logic [N_EVT-1:0] evt_set,
    input  logic             cap_bit,
    output logic [15:0]      status_word
);

    // flag k maps to status bit 8, 11, 12, 13, 14, 15 for k = 0..5
    logic [N_EVT-1:0] flg;
    logic [N_EVT-1:0] clr;

    always_comb begin
        clr = '0;
        if (wr_sel && !be_n[3]) clr = {wdata[31:27], wdata[24]};
    end

    always_ff @(posedge clk) begin
        if (rst) flg <= '0;
        else     flg <= (flg & ~clr) | evt_set;
    end

    assign status_word = {flg[5:1], 2'b01, flg[0], 3'b000, cap_bit, 4'b0000};

    // R4
    evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> ((flg & $past(evt_set)) == $past(evt_set)));

    // R4
    clr_only_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_set == '0) |=> ((flg & ~$past(flg)) == '0));

endmodule

// File: rtl/cfg_space.sv
module cfg_space
    import cfg_space_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h1073,
    parameter logic [15:0] DEVICE_ID     = 16'h000D,
    parameter logic [7:0]  REVISION      = 8'h03,
    parameter logic [7:0]  BASE_CLASS    = 8'h04,
    parameter logic [7:0]  SUB_CLASS     = 8'h01,
    parameter logic [7:0]  PROG_IF       = 8'h00,
    parameter logic [7:0]  HEADER_TYPE   = 8'h00,
    parameter logic [7:0]  INT_PIN       = 8'h01,
    parameter logic [7:0]  MIN_GNT       = 8'h05,
    parameter logic [7:0]  MAX_LAT       = 8'h19,
    parameter logic [15:0] LEGACY_RST    = 16'h907F,
    parameter logic [15:0] LEGACY_EXT_RST = 16'h0000,
    parameter int          BAR_SIZE_LOG2 = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic                  cfg_rd,
    input  logic                  cfg_wr,
    input  logic [3:0]            cfg_be_n,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic [N_EVT-1:0]      evt_set,
    input  logic                  eeprom_present,
    input  logic [15:0]           ee_sub_vid,
    input  logic [15:0]           ee_sub_id,
    output logic                  mem_en,
    output logic                  bm_en,
    output logic                  perr_resp,
    output logic                  serr_en,
    output logic [31:BAR_SIZE_LOG2] mem_base,
    output logic [15:0]           legacy_ctl,
    output logic [15:0]           legacy_ext,
    output logic                  cap_en
);

    localparam logic [31:0] BAR_MASK = ~((32'h1 << BAR_SIZE_LOG2) - 32'h1);

    localparam logic [31:0] RW_RST [N_RW] = '{
        32'h0, 32'h0, 32'h0, 32'h0,
        {LEGACY_EXT_RST, LEGACY_RST}, {DEVICE_ID, VENDOR_ID}, 32'h0};
    localparam logic [31:0] RW_MASK [N_RW] = '{
        32'h0000_0146, 32'h0000_FF00, BAR_MASK, 32'h0000_00FF,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001};
    localparam logic [IDX_W-1:0] RW_IDX [N_RW] = '{
        IDX_CMDSTS, IDX_HDR, IDX_BAR, IDX_INTR,
        IDX_LEGACY, IDX_SUBWR, IDX_PMODE};

    logic [31:0] rw_q [N_RW];
    logic [15:0] status_word;
    logic [31:0] rd_mux;
    cmd_ctl_t    cmd;

    for (genvar i = 0; i < N_RW; i++) begin : g_rw
        cfg_rw_dword #(
            .RST_VAL (RW_RST[i]),
            .WMASK   (RW_MASK[i])
        ) u_word (
            .clk    (clk),
            .rst    (rst),
            .wr_sel (cfg_wr && (cfg_idx == RW_IDX[i])),
            .be_n   (cfg_be_n),
            .wdata  (cfg_wdata),
            .q      (rw_q[i])
        );
    end

    assign cap_en = ~rw_q[S_PMODE][0];

    cfg_status_reg u_status (
        .clk         (clk),
        .rst         (rst),
        .wr_sel      (cfg_wr && (cfg_idx == IDX_CMDSTS)),
        .be_n        (cfg_be_n),
        .wdata       (cfg_wdata),
        .evt_set     (evt_set),
        .cap_bit     (cap_en),
        .status_word (status_word)
    );

    always_comb begin
        cmd       = decode_cmd(rw_q[S_CMD][15:0]);
        mem_en    = cmd.mem_en;
        bm_en     = cmd.bm_en;
        perr_resp = cmd.perr_resp;
        serr_en   = cmd.serr_en;
    end

    assign mem_base   = rw_q[S_BAR][31:BAR_SIZE_LOG2];
    assign legacy_ctl = rw_q[S_LEGACY][15:0];
    assign legacy_ext = rw_q[S_LEGACY][31:16];

    always_comb begin
        case (cfg_idx)
            IDX_ID:     rd_mux = {DEVICE_ID, VENDOR_ID};
            IDX_CMDSTS: rd_mux = {status_word, rw_q[S_CMD][15:0]};
            IDX_CLASS:  rd_mux = {BASE_CLASS, SUB_CLASS, PROG_IF, REVISION};
            IDX_HDR:    rd_mux = {8'h00, HEADER_TYPE, rw_q[S_HDR][15:8], 8'h00};
            IDX_BAR:    rd_mux = rw_q[S_BAR];
            IDX_SUBSYS: rd_mux = eeprom_present ? {ee_sub_id, ee_sub_vid}
                                                : rw_q[S_SUBWR];
            IDX_CAPPTR: rd_mux = {24'h0, cap_en ? CAP_OFFSET : 8'h00};
            IDX_INTR:   rd_mux = {MAX_LAT, MIN_GNT, INT_PIN, rw_q[S_INTR][7:0]};
            IDX_LEGACY: rd_mux = rw_q[S_LEGACY];
            IDX_SUBWR:  rd_mux = rw_q[S_SUBWR];
            IDX_PMCAP:  rd_mux = cap_en ? {24'h0, PM_CAP_ID} : 32'h0;
            IDX_PMODE:  rd_mux = rw_q[S_PMODE];
            default:    rd_mux = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         cfg_rdata <= 32'h0;
        else if (cfg_rd) cfg_rdata <= rd_mux;
    end

    // R1
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && !is_implemented(cfg_idx)) |=> (cfg_rdata == 32'h0));

    // R3
    cmd_mem_en_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_idx == IDX_CMDSTS && !cfg_be_n[0]) |=> (mem_en == $past(cfg_wdata[1])));

    // R5
    cap_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && cfg_idx == IDX_CAPPTR) |=> (cfg_rdata[7:0] == (cap_en ? CAP_OFFSET : 8'h00)));

    // R7
    bar_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && cfg_idx == IDX_BAR) |=> (cfg_rdata[BAR_SIZE_LOG2-1:0] == '0));

    // R8
    rom_ids_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && cfg_idx == IDX_SUBSYS && eeprom_present)
        |=> (cfg_rdata == $past({ee_sub_id, ee_sub_vid})));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> $stable(cfg_rdata));

endmodule

// File: tb/cfg_space_bench.sv
module cfg_space_bench;
    import cfg_space_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_idx = '0;
    logic        cfg_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be_n = 4'hF;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [5:0]  evt_set = '0;
    logic        eeprom_present = 1'b0;
    logic [15:0] ee_sub_vid = '0;
    logic [15:0] ee_sub_id = '0;
    logic        mem_en, bm_en, perr_resp, serr_en, cap_en;
    logic [31:15] mem_base;
    logic [15:0] legacy_ctl, legacy_ext;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cfg_space u_cfg_space (
        .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_rd(cfg_rd),
        .cfg_wr(cfg_wr), .cfg_be_n(cfg_be_n), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .evt_set(evt_set),
        .eeprom_present(eeprom_present), .ee_sub_vid(ee_sub_vid),
        .ee_sub_id(ee_sub_id), .mem_en(mem_en), .bm_en(bm_en),
        .perr_resp(perr_resp), .serr_en(serr_en), .mem_base(mem_base),
        .legacy_ctl(legacy_ctl), .legacy_ext(legacy_ext), .cap_en(cap_en)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  idx;
        logic [3:0]  be_n;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h00, 4'hF, 32'h0,         32'h000D_1073, 8'd6},  // R6 ids
        '{1'b1, 6'h00, 4'h0, 32'hFFFF_FFFF, 32'h000D_1073, 8'd6},  // R6 read-only
        '{1'b0, 6'h01, 4'hF, 32'h0,         32'h0210_0000, 8'd4},  // R4 reset
        '{1'b1, 6'h01, 4'h0, 32'hFFFF_FFFF, 32'h0210_0146, 8'd3},  // R3 mask
        '{1'b0, 6'h02, 4'hF, 32'h0,         32'h0401_0003, 8'd6},  // R6 class
        '{1'b1, 6'h03, 4'h0, 32'hFFFF_FFFF, 32'h0000_FF00, 8'd12}, // R12 latency
        '{1'b1, 6'h04, 4'h0, 32'hFFFF_FFFF, 32'hFFFF_8000, 8'd7},  // R7 sizing
        '{1'b1, 6'h0F, 4'h0, 32'hFFFF_FFFF, 32'h1905_01FF, 8'd12}, // R12 int line
        '{1'b0, 6'h10, 4'hF, 32'h0,         32'h0000_907F, 8'd9},  // R9 reset
        '{1'b1, 6'h10, 4'hE, 32'h1234_5678, 32'h0000_9078, 8'd2},  // R2 lane 0
        '{1'b1, 6'h10, 4'h3, 32'hABCD_0000, 32'hABCD_9078, 8'd2},  // R2 lanes 2,3
        '{1'b0, 6'h0B, 4'hF, 32'h0,         32'h000D_1073, 8'd8},  // R8 shadow rst
        '{1'b1, 6'h11, 4'h0, 32'h5555_AAAA, 32'h5555_AAAA, 8'd8},  // R8 shadow wr
        '{1'b0, 6'h0B, 4'hF, 32'h0,         32'h5555_AAAA, 8'd8},  // R8 shown
        '{1'b1, 6'h20, 4'h0, 32'hFFFF_FFFF, 32'h0000_0000, 8'd1},  // R1 unimpl
        '{1'b0, 6'h0D, 4'hF, 32'h0,         32'h0000_0050, 8'd5},  // R5 ptr
        '{1'b0, 6'h14, 4'hF, 32'h0,         32'h0000_0001, 8'd5},  // R5 cap id
        '{1'b1, 6'h16, 4'h0, 32'hFFFF_FFFF, 32'h0000_0001, 8'd5},  // R5 mode bit
        '{1'b0, 6'h0D, 4'hF, 32'h0,         32'h0000_0000, 8'd5},  // R5 ptr off
        '{1'b0, 6'h01, 4'hF, 32'h0,         32'h0200_0146, 8'd5},  // R5 status b4
        '{1'b0, 6'h14, 4'hF, 32'h0,         32'h0000_0000, 8'd5},  // R5 cap gone
        '{1'b1, 6'h01, 4'hE, 32'h0,         32'h0200_0100, 8'd2}   // R2 cmd lane 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] idx, input logic [3:0] be_n, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_be_n = be_n; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be_n = 4'hF;
    endtask

    task automatic do_read(input logic [5:0] idx, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_idx = idx;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3 R9 R10 reset state at the ports
        check("R3 outputs after reset", {28'h0, mem_en, bm_en, perr_resp, serr_en}, 32'h0);
        check("R9 legacy_ctl reset", {16'h0, legacy_ctl}, 32'h0000_907F);
        check("R11 rdata reset", cfg_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) do_write(VEC[i].idx, VEC[i].be_n, VEC[i].wdata);
            do_read(VEC[i].idx, rd);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
        end

        // R3 outputs follow the command word (only bit 8 left set)
        check("R3 outputs", {28'h0, mem_en, bm_en, perr_resp, serr_en}, 32'h1);
        check("R7 mem_base", {15'h0, mem_base}, 32'h0001_FFFF);
        check("R9 legacy ports", {legacy_ext, legacy_ctl}, 32'hABCD_9078);
        check("R5 cap_en off", {31'h0, cap_en}, 32'h0);

        // R11 read data holds with no read strobe
        repeat (3) @(negedge clk);
        check("R11 hold", cfg_rdata, 32'h0200_0100);

        // R4 event flags
        @(negedge clk); evt_set = 6'h3F;
        @(negedge clk); evt_set = 6'h00;
        do_read(6'h01, rd);
        check("R4 all flags set", rd, 32'hFB00_0100);
        do_write(6'h01, 4'h7, 32'h8800_0000);
        do_read(6'h01, rd);
        check("R4 partial clear", rd, 32'h7300_0100);
        do_write(6'h01, 4'h7, 32'h0000_0000);
        do_read(6'h01, rd);
        check("R4 zero write keeps", rd, 32'h7300_0100);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 6'h01; cfg_be_n = 4'h7; cfg_wdata = 32'hFF00_0000;
        evt_set = 6'h01;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be_n = 4'hF; evt_set = 6'h00;
        do_read(6'h01, rd);
        check("R4 set wins over clear", rd, 32'h0300_0100);

        // R8 external ROM IDs
        eeprom_present = 1'b1; ee_sub_vid = 16'hBEEF; ee_sub_id = 16'hCAFE;
        do_read(6'h0B, rd);
        check("R8 rom ids", rd, 32'hCAFE_BEEF);
        do_write(6'h11, 4'h0, 32'h0000_0000);
        do_read(6'h0B, rd);
        check("R8 shadow ignored", rd, 32'hCAFE_BEEF);
        eeprom_present = 1'b0;
        do_read(6'h0B, rd);
        check("R8 shadow after rom off", rd, 32'h0000_0000);

        // R10 reset returns writable state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        do_read(6'h01, rd);  check("R10 cmd/status", rd, 32'h0210_0000);
        do_read(6'h04, rd);  check("R10 bar", rd, 32'h0);
        do_read(6'h10, rd);  check("R10 legacy", rd, 32'h0000_907F);
        do_read(6'h16, rd);  check("R10 power mode", rd, 32'h0);
        do_read(6'h0B, rd);  check("R10 subsys shadow", rd, 32'h000D_1073);
        do_read(6'h0F, rd);  check("R10 int line", rd, 32'h1905_0100);
        check("R10 ports", {mem_en, bm_en, perr_resp, serr_en, cap_en, legacy_ext},
              {5'b00001, 16'h0000});

        finish_run();
    end

endmodule